// File: doc/BRIEF.md
# DS3 Overhead Error Inserter

This block sits in a DS3 transmit path, just ahead of line coding, and deliberately corrupts chosen overhead bits of the outbound bit stream so that receiving equipment can be tested. It takes one serial bit per clock, plus a one-cycle strobe that marks the first bit of each M-frame. A free-running position tracker follows the 4760-bit M-frame: 7 subframes, each of 8 blocks of 85 bits, with one overhead bit at the head of every block.

At the overhead positions the block can apply three kinds of corruption. It can invert both parity bits. It can XOR the three multiframe bits with a 3-bit pattern. It can XOR each of the 28 framing bits with its own mask bit. Every other bit passes through unchanged: payload, X-bits and C-bits.

The masks live in a small byte-wide register file with a write strobe and a combinational read port. The active copy of the masks is captured at each frame start, so a change made in the middle of a frame takes effect at the next frame boundary. The output is registered, one cycle after the input.

Top module: `ds3_oh_err_ins`

## Requirements
- R1: After reset the output bit is 0 and every mask register reads 0, so no overhead bit is modified.
- R2: The register map is as follows. Address 0x35 holds the parity-invert control in bit 3 and the multiframe mask in bits 2..0. Framing masks 27..24 sit in bits 3..0 of 0x36. Masks 23..16, 15..8 and 7..0 sit in 0x37, 0x38 and 0x39, with the highest index in bit 7. Bits 7..4 of 0x35 and 0x36 always read 0. Any other address reads 0, and a write to it changes no register.
- R3: The output equals the input delayed by exactly one clock for every payload, X and C bit. The same holds for every overhead bit whose mask is 0.
- R4: When the parity-invert control is 1, the overhead bits of subframes 3 and 4 (bit positions 1360 and 2040 of the frame, where bit 0 is the bit that arrives with the strobe) leave inverted.
- R5: Multiframe mask bit k (k = 0..2) is XORed into the overhead bit of subframe 5+k, at frame position 2720 + 680·k.
- R6: Framing mask bit i is XORed into the bit at frame position 680·(i/4) + 85·(2·(i mod 4) + 1). Index 0 is therefore the first framing bit sent, and index 27 is the last.
- R7: Masks are captured when the frame-start strobe is seen. A register write at any other time first affects the frame that starts after it.
- R8: Until the first frame-start strobe after reset, no bit is modified.
- R9: Without a strobe, the position wraps from 4759 to 0 and keeps applying masks. A strobe at any position restarts the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bit_in | input | 1 | Outbound DS3 bit, with the computed parity already in place |
| tx_frame_start | input | 1 | High for the first bit of an M-frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| tx_bit_out | output | 1 | Outbound bit after error insertion, one cycle late |

## Verification
A position tracker that has slipped shows up at the ports as corruption landing on payload bits, or as masked overhead bits passing clean. With non-zero masks this appears at the next overhead position, at most 85 bits later. A stale or early mask capture shows as a mismatch at the first masked overhead bit of the frame that follows a mid-frame write, which is within one frame of 4760 bits. Register decode faults show directly on reg_rdata in the same cycle that the address is presented.

// File: rtl/ds3_oh_pkg.sv
`timescale 1ns/1ps
package ds3_oh_pkg;
    localparam int SUBS_DEF      = 7;
    localparam int BLOCKS_DEF    = 8;
    localparam int BLOCK_LEN_DEF = 85;
    localparam int MBITS_DEF     = 3;
    localparam int P_FIRST_DEF   = 2;
    localparam int P_COUNT_DEF   = 2;

    typedef enum logic [1:0] {
        OH_NONE,
        OH_PARITY,
        OH_MULTI,
        OH_FRAMING
    } oh_kind_e;
endpackage

// File: rtl/ds3_oh_regs.sv
`timescale 1ns/1ps
module ds3_oh_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NUM_F  = 28,
    parameter int NUM_M  = 3,
    parameter logic [ADDR_W-1:0] ADDR_CTL   = 8'h35,
    parameter logic [ADDR_W-1:0] ADDR_FBASE = 8'h36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_F-1:0]  fmask,
    output logic [NUM_M-1:0]  mmask,
    output logic              pinv
);
    localparam int NREG  = (NUM_F + DATA_W - 1) / DATA_W;
    localparam int PAD_W = NREG * DATA_W;
    localparam int CTL_W = NUM_M + 1;
    localparam logic [PAD_W-1:0] F_VALID = PAD_W'((64'd1 << NUM_F) - 64'd1);

    typedef struct packed {
        logic [PAD_W-1:0] fm;
        logic [CTL_W-1:0] ctl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (addr == ADDR_CTL) begin
                st_d.ctl = wdata[CTL_W-1:0];
            end
            for (int i = 0; i < NREG; i++) begin
                if (addr == ADDR_W'(int'(ADDR_FBASE) + i)) begin
                    st_d.fm[(NREG-1-i)*DATA_W +: DATA_W] = wdata;
                end
            end
            st_d.fm = st_d.fm & F_VALID;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTL) begin
            rdata = DATA_W'(st_q.ctl);
        end
        for (int i = 0; i < NREG; i++) begin
            if (addr == ADDR_W'(int'(ADDR_FBASE) + i)) begin
                rdata = st_q.fm[(NREG-1-i)*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fmask = st_q.fm[NUM_F-1:0];
    assign mmask = st_q.ctl[NUM_M-1:0];
    assign pinv  = st_q.ctl[NUM_M];
endmodule

// File: rtl/ds3_oh_pos.sv
`timescale 1ns/1ps
module ds3_oh_pos #(
    parameter int SUBS      = 7,
    parameter int BLOCKS    = 8,
    parameter int BLOCK_LEN = 85,
    parameter int SUB_W     = $clog2(SUBS),
    parameter int BLK_W     = $clog2(BLOCKS),
    parameter int BIT_W     = $clog2(BLOCK_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    output logic             cur_valid,
    output logic [SUB_W-1:0] cur_sub,
    output logic [BLK_W-1:0] cur_blk,
    output logic [BIT_W-1:0] cur_bit
);
    typedef struct packed {
        logic             sync;
        logic [SUB_W-1:0] sub;
        logic [BLK_W-1:0] blk;
        logic [BIT_W-1:0] bitp;
    } pos_t;

    pos_t st_d, st_q;

    // st_d is the position of the bit presented in this cycle
    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d      = '0;
            st_d.sync = 1'b1;
        end else if (st_q.sync) begin
            if (st_q.bitp == BIT_W'(BLOCK_LEN - 1)) begin
                st_d.bitp = '0;
                if (st_q.blk == BLK_W'(BLOCKS - 1)) begin
                    st_d.blk = '0;
                    st_d.sub = (st_q.sub == SUB_W'(SUBS - 1)) ? '0 : st_q.sub + 1'b1;
                end else begin
                    st_d.blk = st_q.blk + 1'b1;
                end
            end else begin
                st_d.bitp = st_q.bitp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_valid = st_d.sync;
    assign cur_sub   = st_d.sub;
    assign cur_blk   = st_d.blk;
    assign cur_bit   = st_d.bitp;
endmodule

// File: rtl/ds3_oh_insert.sv
`timescale 1ns/1ps
module ds3_oh_insert
    import ds3_oh_pkg::*;
#(
    parameter int SUBS    = 7,
    parameter int BLOCKS  = 8,
    parameter int NUM_F   = 28,
    parameter int NUM_M   = 3,
    parameter int P_FIRST = 2,
    parameter int P_COUNT = 2,
    parameter int SUB_W   = 3,
    parameter int BLK_W   = 3,
    parameter int BIT_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             bit_in,
    input  logic             cur_valid,
    input  logic [SUB_W-1:0] cur_sub,
    input  logic [BLK_W-1:0] cur_blk,
    input  logic [BIT_W-1:0] cur_bit,
    input  logic [NUM_F-1:0] fmask_in,
    input  logic [NUM_M-1:0] mmask_in,
    input  logic             pinv_in,
    output logic             bit_out
);
    localparam int F_PER_SUB = BLOCKS / 2;

    typedef struct packed {
        logic [NUM_F-1:0] fm;
        logic [NUM_M-1:0] mm;
        logic             pinv;
        logic             out;
    } ins_t;

    ins_t     st_d, st_q;
    oh_kind_e kind;
    int       oh_idx;
    logic     flip;

    always_comb begin
        kind   = OH_NONE;
        oh_idx = 0;
        if (cur_valid && (cur_bit == '0)) begin
            if (cur_blk[0]) begin
                kind   = OH_FRAMING;
                oh_idx = int'(cur_sub) * F_PER_SUB + int'(cur_blk) / 2;
            end else if (cur_blk == '0) begin
                if ((int'(cur_sub) >= P_FIRST) && (int'(cur_sub) < P_FIRST + P_COUNT)) begin
                    kind = OH_PARITY;
                end else if (int'(cur_sub) >= SUBS - NUM_M) begin
                    kind   = OH_MULTI;
                    oh_idx = int'(cur_sub) - (SUBS - NUM_M);
                end
            end
        end
    end

    always_comb begin
        flip = 1'b0;
        unique case (kind)
            OH_PARITY: flip = st_q.pinv;
            OH_MULTI: begin
                for (int k = 0; k < NUM_M; k++) begin
                    if (k == oh_idx) flip = st_q.mm[k];
                end
            end
            OH_FRAMING: begin
                for (int k = 0; k < NUM_F; k++) begin
                    if (k == oh_idx) flip = st_q.fm[k];
                end
            end
            default: flip = 1'b0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.out = bit_in ^ flip;
        if (frame_start) begin
            st_d.fm   = fmask_in;
            st_d.mm   = mmask_in;
            st_d.pinv = pinv_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_out = st_q.out;
endmodule

// File: rtl/ds3_oh_err_ins.sv
`timescale 1ns/1ps
module ds3_oh_err_ins #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SUBS      = ds3_oh_pkg::SUBS_DEF,
    parameter int BLOCKS    = ds3_oh_pkg::BLOCKS_DEF,
    parameter int BLOCK_LEN = ds3_oh_pkg::BLOCK_LEN_DEF,
    parameter int NUM_M     = ds3_oh_pkg::MBITS_DEF,
    parameter int P_FIRST   = ds3_oh_pkg::P_FIRST_DEF,
    parameter int P_COUNT   = ds3_oh_pkg::P_COUNT_DEF,
    parameter logic [ADDR_W-1:0] ADDR_CTL   = 8'h35,
    parameter logic [ADDR_W-1:0] ADDR_FBASE = 8'h36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_bit_in,
    input  logic              tx_frame_start,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_bit_out
);
    localparam int NUM_F = SUBS * (BLOCKS / 2);
    localparam int NREG  = (NUM_F + DATA_W - 1) / DATA_W;
    localparam int SUB_W = $clog2(SUBS);
    localparam int BLK_W = $clog2(BLOCKS);
    localparam int BIT_W = $clog2(BLOCK_LEN);

    logic [NUM_F-1:0] fmask;
    logic [NUM_M-1:0] mmask;
    logic             pinv;
    logic             cur_valid;
    logic [SUB_W-1:0] cur_sub;
    logic [BLK_W-1:0] cur_blk;
    logic [BIT_W-1:0] cur_bit;

    ds3_oh_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_F(NUM_F), .NUM_M(NUM_M),
        .ADDR_CTL(ADDR_CTL), .ADDR_FBASE(ADDR_FBASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .fmask(fmask), .mmask(mmask), .pinv(pinv)
    );

    ds3_oh_pos #(
        .SUBS(SUBS), .BLOCKS(BLOCKS), .BLOCK_LEN(BLOCK_LEN),
        .SUB_W(SUB_W), .BLK_W(BLK_W), .BIT_W(BIT_W)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .frame_start(tx_frame_start),
        .cur_valid(cur_valid), .cur_sub(cur_sub), .cur_blk(cur_blk), .cur_bit(cur_bit)
    );

    ds3_oh_insert #(
        .SUBS(SUBS), .BLOCKS(BLOCKS), .NUM_F(NUM_F), .NUM_M(NUM_M),
        .P_FIRST(P_FIRST), .P_COUNT(P_COUNT),
        .SUB_W(SUB_W), .BLK_W(BLK_W), .BIT_W(BIT_W)
    ) u_ins (
        .clk(clk), .rst_n(rst_n), .frame_start(tx_frame_start), .bit_in(tx_bit_in),
        .cur_valid(cur_valid), .cur_sub(cur_sub), .cur_blk(cur_blk), .cur_bit(cur_bit),
        .fmask_in(fmask), .mmask_in(mmask), .pinv_in(pinv), .bit_out(tx_bit_out)
    );
endmodule

// File: rtl/ds3_oh_err_ins_chk.sv
`timescale 1ns/1ps
module ds3_oh_err_ins_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NREG   = 4,
    parameter logic [ADDR_W-1:0] ADDR_CTL   = 8'h35,
    parameter logic [ADDR_W-1:0] ADDR_FBASE = 8'h36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_bit_in,
    input logic              tx_frame_start,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              tx_bit_out
);
    logic seen_q;
    logic unmapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (tx_frame_start) seen_q <= 1'b1;
    end

    assign unmapped = (reg_addr != ADDR_CTL) &&
                      ((int'(reg_addr) < int'(ADDR_FBASE)) ||
                       (int'(reg_addr) >= int'(ADDR_FBASE) + NREG));

    // R1
    reset_out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tx_bit_out == 1'b0));

    // R2
    upper_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr == ADDR_CTL) || (reg_addr == ADDR_FBASE)) |-> (reg_rdata[DATA_W-1:4] == '0));

    // R2
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (reg_rdata == '0));

    // R2
    full_byte_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == ADDR_W'(int'(ADDR_FBASE) + 1))) |=>
        ((reg_addr != ADDR_W'(int'(ADDR_FBASE) + 1)) || (reg_rdata == $past(reg_wdata))));

    // R3
    frame_head_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_start |=> (tx_bit_out == $past(tx_bit_in)));

    // R8
    unsynced_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && !tx_frame_start) |=> (tx_bit_out == $past(tx_bit_in)));
endmodule

bind ds3_oh_err_ins ds3_oh_err_ins_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG),
    .ADDR_CTL(ADDR_CTL), .ADDR_FBASE(ADDR_FBASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_bit_in(tx_bit_in), .tx_frame_start(tx_frame_start),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_bit_out(tx_bit_out)
);

// File: tb/ds3_oh_err_ins_bench.sv
`timescale 1ns/1ps
module ds3_oh_err_ins_bench;
    localparam int FRAME = 4760;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_bit_in, tx_frame_start, reg_wr;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       tx_bit_out;

    always #2 clk = ~clk;

    ds3_oh_err_ins u_ds3_oh_err_ins (
        .clk(clk), .rst_n(rst_n), .tx_bit_in(tx_bit_in), .tx_frame_start(tx_frame_start),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_bit_out(tx_bit_out)
    );

    int vectors = 0;
    int misses  = 0;

    logic        b_p, a_p;
    logic [2:0]  b_m, a_m;
    logic [27:0] b_f, a_f;
    bit          synced, pend, dirty, realigned;
    int          pos;
    logic        exp_bit;
    string       pend_tag;

    function automatic string tag_of(int p);
        int s = p / 680;
        int w = p % 680;
        int blk = w / 85;
        if (w % 85 != 0) return "R3 payload";
        if (blk % 2 == 1) return "R6 framing";
        if (blk != 0) return "R3 stuffing";
        if (s < 2) return "R3 xbit";
        if (s < 4) return "R4 parity";
        return "R5 multiframe";
    endfunction

    function automatic logic flip_of(int p);
        int s = p / 680;
        int w = p % 680;
        int blk = w / 85;
        if (w % 85 != 0) return 1'b0;
        if (blk % 2 == 1) return a_f[s*4 + blk/2];
        if (blk != 0) return 1'b0;
        if (s == 2 || s == 3) return a_p;
        if (s >= 4) return a_m[s-4];
        return 1'b0;
    endfunction

    function automatic logic [7:0] rd_model(logic [7:0] a);
        case (a)
            8'h35: return {4'h0, b_p, b_m};
            8'h36: return {4'h0, b_f[27:24]};
            8'h37: return b_f[23:16];
            8'h38: return b_f[15:8];
            8'h39: return b_f[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic apply_wr(logic [7:0] a, logic [7:0] d);
        case (a)
            8'h35: {b_p, b_m} = d[3:0];
            8'h36: b_f[27:24] = d[3:0];
            8'h37: b_f[23:16] = d;
            8'h38: b_f[15:8]  = d;
            8'h39: b_f[7:0]   = d;
            default: ;
        endcase
    endtask

    task automatic check1(string tag, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %02h expected %02h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic step(logic b, bit fs, bit wr, logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        if (pend) check1(pend_tag, tx_bit_out, exp_bit);
        tx_bit_in      = b;
        tx_frame_start = fs;
        reg_wr         = wr;
        reg_addr       = a;
        reg_wdata      = d;
        if (fs) begin
            synced = 1'b1; pos = 0;
            a_p = b_p; a_m = b_m; a_f = b_f;
            dirty = 1'b0;
        end else if (synced) begin
            pos = (pos + 1) % FRAME;
        end
        exp_bit  = synced ? (b ^ flip_of(pos)) : b;
        pend_tag = synced ? tag_of(pos) : "R8 before first strobe";
        if (dirty)     pend_tag = {pend_tag, " R7 midframe write pending"};
        if (realigned) pend_tag = {pend_tag, " R9"};
        pend = 1'b1;
        if (wr) begin
            if (synced) dirty = 1'b1;
            apply_wr(a, d);
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [7:0] d);
        step(1'($urandom), 1'b0, 1'b1, a, d);
    endtask

    task automatic rd_chk(logic [7:0] a, string tag);
        step(1'($urandom), 1'b0, 1'b0, a, 8'h00);
        #1;
        check8(tag, reg_rdata, rd_model(a));
    endtask

    task automatic run_bits(int n, bit strobe, int wr_at);
        for (int i = 0; i < n; i++) begin
            if (i == wr_at)
                step(1'($urandom), strobe && (i == 0), 1'b1,
                     8'h35 + 8'($urandom % 5), 8'($urandom));
            else
                step(1'($urandom), strobe && (i == 0), 1'b0, 8'h00, 8'h00);
        end
    endtask

    initial begin
        #(4 * 200000);
        misses++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        b_p = 0; b_m = 0; b_f = 0; a_p = 0; a_m = 0; a_f = 0;
        synced = 0; pend = 0; dirty = 0; realigned = 0; pos = 0;
        rst_n = 1'b0; tx_bit_in = 1'b1; tx_frame_start = 1'b0;
        reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
        repeat (3) @(negedge clk);
        check1("R1 reset output", tx_bit_out, 1'b0);
        rst_n = 1'b1;
        for (int a = 8'h35; a <= 8'h39; a++) rd_chk(8'(a), "R1 reset register");

        // R8: traffic before any strobe, then a register write that must not matter yet
        run_bits(150, 1'b0, -1);
        wr_reg(8'h37, 8'hFF);
        run_bits(150, 1'b0, -1);

        // R2: register map, unused bits, unmapped addresses
        wr_reg(8'h36, 8'hFF); rd_chk(8'h36, "R2 fmask hi nibble");
        wr_reg(8'h35, 8'hFF); rd_chk(8'h35, "R2 ctl nibble");
        wr_reg(8'h37, 8'hA5); rd_chk(8'h37, "R2 fmask 23..16");
        wr_reg(8'h38, 8'h3C); rd_chk(8'h38, "R2 fmask 15..8");
        wr_reg(8'h39, 8'h81); rd_chk(8'h39, "R2 fmask 7..0");
        wr_reg(8'h50, 8'hFF); rd_chk(8'h50, "R2 unmapped read");
        wr_reg(8'h34, 8'h77); rd_chk(8'h34, "R2 unmapped read");
        for (int a = 8'h35; a <= 8'h39; a++) rd_chk(8'(a), "R2 unmapped write no effect");

        // R3: clean frame with all masks zero
        for (int a = 8'h35; a <= 8'h39; a++) wr_reg(8'(a), 8'h00);
        run_bits(FRAME, 1'b1, -1);

        // R4 R5 R6 R7: random masks, each frame with a mid-frame write
        for (int f = 0; f < 3; f++) begin
            for (int a = 8'h35; a <= 8'h39; a++) wr_reg(8'(a), 8'($urandom));
            run_bits(FRAME - 5, 1'b1, 100 + int'($urandom % 4000));
        end

        // R9: free-running wrap without a strobe
        run_bits(FRAME + 200, 1'b0, 300);

        // directed all-ones masks
        wr_reg(8'h35, 8'h0F);
        for (int a = 8'h36; a <= 8'h39; a++) wr_reg(8'(a), 8'hFF);
        run_bits(FRAME - 5, 1'b1, -1);

        // R9: early strobe realigns the count
        run_bits(1000, 1'b1, -1);
        realigned = 1'b1;
        wr_reg(8'h35, 8'h0A);
        run_bits(FRAME + 10, 1'b1, -1);

        step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule